// File: doc/BRIEF.md
# Single-Channel Ping-Pong Raw Sample Capture

This block takes the full-rate sample set of a multi-channel acquisition front end, picks out one channel by an index held in a host register, and stores that channel's sample together with the level of the switching reference seen at the same instant. Storage is split into two equal banks used in turn. While one bank fills, the host reads the other, so a host that answers every fill notification in time receives an unbroken stream of raw samples.

Capture never stalls. Each time a bank's last entry is written, a one-cycle notification is raised with the number of the bank just filled, and writing moves to the other bank at once. A host that misses a notification loses that block, because the block is overwritten on the next pass. The channel index is taken at the first write of each block, so a block never mixes two channels. The block is controlled by a two-state machine. In state ST_FILL0, writes go to bank 0. In state ST_FILL1, writes go to bank 1. The only transition is the wrap: on the write of the last entry, ST_FILL0 goes to ST_FILL1 and ST_FILL1 goes to ST_FILL0. Reset enters ST_FILL0.

Top module: `rawcap_pingpong`

## Requirements
- R1: After reset the machine is in ST_FILL0 with write index 0, `full_pulse` is low and `rd_data` is zero.
- R2: Each stored word puts the low 18 bits of the selected 32-bit slot in bits 17:0 and the reference level in bit 31. Bits 30:18 are zero.
- R3: A `chan_sel` value of k selects slot k of `smp_bus`, which is bits 32k+31 down to 32k.
- R4: `chan_sel` is sampled only at the first write of a block (index 0). That channel is used for the whole block, even if `chan_sel` changes during the block.
- R5: Each cycle with `smp_valid` high writes one word at the next index of the active bank. Indexes run from 0 to DEPTH-1.
- R6: The cycle after the write to index DEPTH-1, `full_pulse` is high for exactly one cycle and `full_bank` gives the bank just filled. The first filled bank is 0, and the banks then alternate.
- R7: A read with `rd_en` high returns, one cycle later, the word at `rd_addr` of the bank not being written in the request cycle. `rd_data` holds its value while `rd_en` is low.
- R8: Writing never waits for the host. A bank that is not read is overwritten on its next fill, and it then holds only the newer samples.
- R9: Cycles with `smp_valid` low write nothing and do not advance the index, whatever `smp_bus` and `ref_lvl` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample set is present on `smp_bus` |
| smp_bus | input | NUM_CH*32 | All channel slots, 32 bits each, sample in the low 18 bits |
| ref_lvl | input | 1 | Switching reference level for the current sample set |
| chan_sel | input | $clog2(NUM_CH) | Host-register channel index |
| rd_en | input | 1 | Host read request |
| rd_addr | input | $clog2(DEPTH) | Entry to read in the inactive bank |
| rd_data | output | 32 | Read word, one cycle after the request |
| full_pulse | output | 1 | One-cycle notification that a bank has filled |
| full_bank | output | 1 | Number of the bank that has just filled |

## Verification
The bench changes the channel index in the middle of a block. A design that applied the new index at once would store a block that mixes two channels. The bench also drives changing bus data and reference levels on idle cycles. A design that wrote on those cycles would shift every later entry and move the fill pulse. In one stretch the bench sends samples back to back and stops reading, then checks that the next block it reads holds only the newest samples. This catches a design that stalls or keeps old data. Every read burst is compared against the bank that should be inactive, so a design that read the bank being written would return partly new data.

// File: rtl/rawcap_pkg.sv
package rawcap_pkg;
    localparam int SLOT_W  = 32;
    localparam int SMP_W   = 18;
    localparam int REF_POS = 31;

    typedef enum logic {
        ST_FILL0 = 1'b0,
        ST_FILL1 = 1'b1
    } fill_state_e;

    function automatic logic [SLOT_W-1:0] pack_word(
        input logic [SMP_W-1:0] smp,
        input logic             lvl
    );
        logic [SLOT_W-1:0] w;
        w          = '0;
        w[SMP_W-1:0] = smp;
        w[REF_POS] = lvl;
        return w;
    endfunction
endpackage

// File: rtl/rawcap_chan_pick.sv
module rawcap_chan_pick
    import rawcap_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*SLOT_W-1:0] slots,
    input  logic [CH_W-1:0]          ch,
    input  logic                     lvl,
    output logic [SLOT_W-1:0]        word
);
    localparam int UP_W = SLOT_W - SMP_W;

    logic [SMP_W-1:0] smp_arr [NUM_CH];
    logic [UP_W-1:0]  upper_arr [NUM_CH];
    logic [NUM_CH-1:0] upper_red;
    logic              unused_upper;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        assign smp_arr[g]   = slots[g*SLOT_W +: SMP_W];
        assign upper_arr[g] = slots[g*SLOT_W+SMP_W +: UP_W];
        assign upper_red[g] = ^upper_arr[g];
    end

    assign unused_upper = ^upper_red;

    always_comb begin
        if (32'(ch) < NUM_CH) word = pack_word(smp_arr[ch], lvl);
        else                  word = pack_word('0, lvl);
    end
endmodule

// File: rtl/rawcap_seq.sv
module rawcap_seq
    import rawcap_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int DEPTH    = 512,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   chan_sel,
    output logic              we,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CH_W-1:0]   cur_ch,
    output logic              full_pulse,
    output logic              full_bank
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    fill_state_e       state_q, state_d;
    logic [ADDR_W-1:0] idx_q;
    logic [CH_W-1:0]   ch_q;
    logic              wrap;
    logic              pulse_q, pbank_q;

    assign wrap = smp_valid && (idx_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL0: if (wrap) state_d = ST_FILL1;
            ST_FILL1: if (wrap) state_d = ST_FILL0;
            default:            state_d = ST_FILL0;
        endcase
    end

    always_comb begin
        we      = smp_valid;
        wr_bank = (state_q == ST_FILL1);
        wr_addr = idx_q;
        cur_ch  = (idx_q == '0) ? chan_sel : ch_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            ch_q    <= '0;
            pulse_q <= 1'b0;
            pbank_q <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (wrap) pbank_q <= wr_bank;
            if (smp_valid) begin
                idx_q <= wrap ? '0 : idx_q + 1'b1;
                if (idx_q == '0) ch_q <= chan_sel;
            end
        end
    end

    assign full_pulse = pulse_q;
    assign full_bank  = pbank_q;
endmodule

// File: rtl/rawcap_banks.sv
module rawcap_banks
    import rawcap_pkg::*;
#(
    parameter int DEPTH   = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SLOT_W-1:0] rd_data
);
    logic [SLOT_W-1:0] bank_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [SLOT_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wr_bank == 1'(g))) mem[wr_addr] <= wr_data;
        end
        assign bank_out[g] = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= bank_out[~wr_bank];
    end
endmodule

// File: rtl/rawcap_pingpong.sv
module rawcap_pingpong
    import rawcap_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int DEPTH   = 512,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [NUM_CH*SLOT_W-1:0] smp_bus,
    input  logic                     ref_lvl,
    input  logic [CH_W-1:0]          chan_sel,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [SLOT_W-1:0]        rd_data,
    output logic                     full_pulse,
    output logic                     full_bank
);
    logic              we, wr_bank;
    logic [ADDR_W-1:0] wr_addr;
    logic [CH_W-1:0]   cur_ch;
    logic [SLOT_W-1:0] wr_word;

    rawcap_seq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .chan_sel   (chan_sel),
        .we         (we),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .cur_ch     (cur_ch),
        .full_pulse (full_pulse),
        .full_bank  (full_bank)
    );

    rawcap_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .slots (smp_bus),
        .ch    (cur_ch),
        .lvl   (ref_lvl),
        .word  (wr_word)
    );

    rawcap_banks #(.DEPTH(DEPTH)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_word),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/rawcap_pingpong_chk.sv
module rawcap_pingpong_chk
    import rawcap_pkg::*;
#(
    parameter int DEPTH   = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              rd_en,
    input logic [SLOT_W-1:0] rd_data,
    input logic              full_pulse,
    input logic              full_bank
);
    logic [ADDR_W-1:0] cnt_q;
    logic              exp_pulse_q;
    logic              nxt_bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            exp_pulse_q <= 1'b0;
            nxt_bank_q  <= 1'b0;
        end else begin
            exp_pulse_q <= smp_valid && (32'(cnt_q) == DEPTH - 1);
            if (smp_valid) cnt_q <= (32'(cnt_q) == DEPTH - 1) ? '0 : cnt_q + 1'b1;
            if (full_pulse) nxt_bank_q <= ~nxt_bank_q;
        end
    end

    // R6
    pulse_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_pulse == exp_pulse_q);

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_pulse |=> !full_pulse);

    // R6
    bank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_pulse |-> (full_bank == nxt_bank_q));

    // R2
    word_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SLOT_W-2:SMP_W] == '0);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind rawcap_pingpong rawcap_pingpong_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .full_pulse (full_pulse),
    .full_bank  (full_bank)
);

// File: tb/test_rawcap_pingpong.sv
module test_rawcap_pingpong;
    localparam int NUM_CH = 4;
    localparam int DEPTH  = 16;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = $clog2(DEPTH);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   smp_valid = 1'b0;
    logic [NUM_CH*32-1:0]   smp_bus = '0;
    logic                   ref_lvl = 1'b0;
    logic [CH_W-1:0]        chan_sel = '0;
    logic                   rd_en = 1'b0;
    logic [ADDR_W-1:0]      rd_addr = '0;
    logic [31:0]            rd_data;
    logic                   full_pulse, full_bank;

    rawcap_pingpong #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) i_rawcap_pingpong (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
        .ref_lvl(ref_lvl), .chan_sel(chan_sel), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .full_pulse(full_pulse), .full_bank(full_bank)
    );

    always #4 clk = ~clk;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    logic [31:0] exp_mem [2][DEPTH];
    bit          fullq [$];
    int          m_idx  = 0;
    bit          m_bank = 1'b0;
    int          m_ch   = 0;
    int          n_smp  = 0;

    bit read_on = 1'b0;
    bit rd_req  = 1'b0;
    bit rd_bank = 1'b0;
    bit busy    = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_val(input int n, input int ch);
        return {14'(14'h155 ^ ch), 18'(n * 37 + ch * 4099 + 1)};
    endfunction

    // Driver: one sample set, then idle cycles carrying junk (R9)
    task automatic send(input int gap);
        logic [31:0] s;
        for (int c = 0; c < NUM_CH; c++) smp_bus[c*32 +: 32] = slot_val(n_smp, c);
        ref_lvl   = (n_smp % 3) == 1;
        smp_valid = 1'b1;
        if (m_idx == 0) m_ch = int'(chan_sel);
        s = slot_val(n_smp, m_ch);
        exp_mem[m_bank][m_idx] = {ref_lvl, 13'b0, s[17:0]};
        if (m_idx == DEPTH - 1) begin
            fullq.push_back(m_bank);
            m_bank = ~m_bank;
            m_idx  = 0;
        end else m_idx++;
        n_smp++;
        @(negedge clk);
        smp_valid = 1'b0;
        for (int g = 0; g < gap; g++) begin
            smp_bus = {NUM_CH{32'hDEAD_BEEF ^ 32'(g)}};
            ref_lvl = ~ref_lvl;
            @(negedge clk);
        end
    endtask

    // Monitor: pops expected fill events (R6, R8)
    always @(negedge clk) begin
        if (rst_n && full_pulse && !done) begin
            if (fullq.size() == 0) check(1'b0, "R6 unexpected full_pulse", 1, 0);
            else begin
                bit eb;
                eb = fullq.pop_front();
                check(full_bank == eb, "R6 full_bank", full_bank, eb);
                if (read_on) begin
                    rd_bank = eb;
                    rd_req  = 1'b1;
                end
            end
        end
    end

    // Host reader: burst over the just-filled bank (R2 R3 R4 R5 R7 R8)
    initial begin
        forever begin
            logic [31:0] hold;
            wait (rd_req);
            rd_req = 1'b0;
            busy   = 1'b1;
            rd_en  = 1'b1;
            rd_addr = '0;
            for (int i = 0; i < DEPTH; i++) begin
                @(negedge clk);
                check(rd_data == exp_mem[rd_bank][i], "R2 R3 R4 R5 R7 R8 read word",
                      rd_data, exp_mem[rd_bank][i]);
                if (i < DEPTH - 1) rd_addr = ADDR_W'(i + 1);
                else               rd_en = 1'b0;
            end
            @(negedge clk);
            hold = rd_data;
            repeat (3) @(negedge clk);
            check(rd_data == hold, "R7 hold without rd_en", rd_data, hold);
            busy = 1'b0;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(full_pulse == 1'b0, "R1 full_pulse after reset", full_pulse, 0);
        check(rd_data == 32'h0, "R1 rd_data after reset", rd_data, 0);

        // Phase A: channel 1, spaced samples, every block read
        read_on  = 1'b1;
        chan_sel = 2'd1;
        for (int i = 0; i < DEPTH + DEPTH/2; i++) send(3);
        // R4: change mid-block, must apply from the next block only
        chan_sel = 2'd2;
        for (int i = 0; i < DEPTH/2 + DEPTH; i++) send(3);

        // Phase B: no reads, back-to-back samples, blocks overwritten (R8)
        while (busy) @(negedge clk);
        read_on  = 1'b0;
        chan_sel = 2'd3;
        for (int i = 0; i < 2 * DEPTH; i++) send(0);

        // Phase C: reads resume, newest data expected (R8), channel 0 (R3)
        read_on  = 1'b1;
        chan_sel = 2'd0;
        for (int i = 0; i < 2 * DEPTH; i++) send(3);

        repeat (10) @(negedge clk);
        while (busy || rd_req) @(negedge clk);
        // R6: every expected fill event was seen
        check(fullq.size() == 0, "R6 missing full_pulse", fullq.size(), 0);
        check(full_pulse == 1'b0, "R6 pulse idle at end", full_pulse, 0);
        finish_run();
    end
endmodule